// File: doc/BRIEF.md
# RC Oscillator Enable and Ready Controller

This block owns the run/stop control of an on-chip RC oscillator and tells the rest of the chip when that oscillator can be relied on. Software reaches a small control word over a simple register bus. Through it, software sets or clears the oscillator enable, programs a five-bit user trim, and reads back a ready flag. The trim is added to a factory calibration value to give the code that tunes the oscillator. The sum saturates, so the code never wraps.

Hardware events also act on the enable. On wake-up from a low-power stop or standby state, the enable is forced on. It is also forced on when the external crystal oscillator fails while it feeds the system clock, either directly or through the PLL. The enable is protected: a software clear is dropped while the RC oscillator is the system clock, or has been selected to become it.

The ready flag is produced in the oscillator's own clock domain and passed to the bus clock through a synchronizer. It rises a programmable number of oscillator cycles after the enable is set. It falls exactly six oscillator cycles after the enable is cleared. A register access normally completes at once. An access that starts while the system clock source is switching is held off with a wait request for a fixed one or two cycles.

Top module: `rcosc_ctrl`

## Requirements
- R1: After reset the enable output is 1, the trim field holds 16 and the ready output is 0.
- R2: The control word has the enable at bit 0, the ready flag at bit 1, a constant 0 at bit 2 and the trim field at bits 7:3. Writes to bits 2:1 have no effect.
- R3: `trim_code` equals `factory_cal` plus the trim field, clamped at 255 when the sum exceeds 8 bits.
- R4: After the enable rises, the ready flag is set in the oscillator domain on exactly the STARTUP_CYCLES-th oscillator rising edge. `osc_ready` follows two bus clock edges later.
- R5: After the enable falls, the ready flag is cleared in the oscillator domain on exactly the sixth oscillator rising edge. `osc_ready` follows two bus clock edges later.
- R6: A `lowpower_exit` pulse sets the enable on the next bus clock edge.
- R7: `ext_osc_fail` sets the enable on the next edge only while `ext_osc_in_use` is 1. Otherwise it has no effect.
- R8: A software write of 0 to the enable is ignored while `rc_in_use` is 1.
- R9: If a software clear and a hardware set fall in the same cycle, the enable ends up 1.
- R10: An access made while `clk_switching` is 0 sees `wait_req` at 0. An access that starts while `clk_switching` is 1 sees `wait_req` high for exactly SWITCH_WAIT cycles (default 2) and then completes. `wait_req` is never high without an access.
- R11: A write changes the control word only on the cycle in which the access completes (access present and `wait_req` low).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| osc_clk | input | 1 | RC oscillator clock (modelled) |
| wr_en | input | 1 | Write request, held until completion |
| rd_en | input | 1 | Read request, held until completion |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data (control word) |
| wait_req | output | 1 | Access must be held another cycle |
| clk_switching | input | 1 | System clock source switch in progress |
| lowpower_exit | input | 1 | Pulse on exit from stop or standby |
| ext_osc_fail | input | 1 | External oscillator failure detected |
| ext_osc_in_use | input | 1 | External oscillator drives the system clock |
| rc_in_use | input | 1 | RC oscillator is, or is selected to become, the system clock |
| factory_cal | input | 8 | Factory calibration value |
| osc_en | output | 1 | Oscillator enable |
| osc_ready | output | 1 | Ready flag in the bus domain |
| trim_code | output | 8 | Saturated calibration plus trim |

## Verification
The hardest behaviour to pin down from the ports is the exact six-cycle fall of the ready flag, because it is hidden behind two clock crossings. The bench runs the oscillator clock at three times the bus period, with a fixed phase offset, so every crossing lands on a known edge. It counts oscillator edges from the observed enable fall and checks the flag one nanosecond after the sixth edge, when it must still be high. It checks again one nanosecond after the second following bus edge, when it must be low, so an off-by-one in either direction is caught. The same method covers the startup count. The in-use lock-out and the same-cycle clear-versus-set race are reached by driving `rc_in_use` and `lowpower_exit` in the exact cycle in which a write completes.

// File: rtl/rcosc_pkg.sv
package rcosc_pkg;

   // Bit positions of the control word; the bus decodes them.
   localparam int unsigned EN_BIT   = 0;
   localparam int unsigned RDY_BIT  = 1;
   localparam int unsigned ZERO_BIT = 2;
   localparam int unsigned TRIM_LSB = 3;

   // Oscillator-domain sequencer states; bit 1 is the ready flag.
   typedef enum logic [1:0] {
      OSC_OFF      = 2'b00,
      OSC_STARTING = 2'b01,
      OSC_READY    = 2'b10,
      OSC_DRAINING = 2'b11
   } osc_state_e;

   function automatic int unsigned width_for(input int unsigned max_val);
      int unsigned w;
      w = 1;
      while ((1 << w) <= max_val) w++;
      return w;
   endfunction

endpackage

// File: rtl/rcosc_sync.sv
module rcosc_sync #(
   parameter int unsigned STAGES  = 2,
   parameter bit          RST_VAL = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);
   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("rcosc_sync: STAGES must be at least 2");
      end
   endgenerate

   logic [STAGES-1:0] chain;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= {STAGES{RST_VAL}};
      else        chain <= {chain[STAGES-2:0], d};
   end

   assign q = chain[STAGES-1];
endmodule

// File: rtl/rcosc_trim_sum.sv
module rcosc_trim_sum #(
   parameter int unsigned CAL_W    = 8,
   parameter int unsigned TRIM_W   = 5,
   parameter bit          SATURATE = 1'b1
) (
   input  logic [CAL_W-1:0]  cal,
   input  logic [TRIM_W-1:0] trim,
   output logic [CAL_W-1:0]  code
);
   generate
      if (TRIM_W > CAL_W) begin : g_bad_width
         $error("rcosc_trim_sum: TRIM_W must not exceed CAL_W");
      end
   endgenerate

   logic [CAL_W:0] full_sum;
   assign full_sum = {1'b0, cal} + {{(CAL_W+1-TRIM_W){1'b0}}, trim};

   generate
      if (SATURATE) begin : g_clamp
         assign code = full_sum[CAL_W] ? {CAL_W{1'b1}} : full_sum[CAL_W-1:0];
      end else begin : g_wrap
         logic carry_unused;
         assign carry_unused = full_sum[CAL_W];
         assign code = full_sum[CAL_W-1:0];
      end
   endgenerate
endmodule

// File: rtl/rcosc_ready_seq.sv
module rcosc_ready_seq
   import rcosc_pkg::*;
#(
   parameter int unsigned STARTUP_CYCLES = 64,
   parameter int unsigned OFF_CYCLES     = 6,
   parameter int unsigned SYNC_STAGES    = 2
) (
   input  logic osc_clk,
   input  logic osc_rst_n,
   input  logic en_async,
   output logic ready_osc
);
   // Counted from the enable edge: SYNC_STAGES edges of synchronizer,
   // one edge entering the timed state, then LAST+1 counting edges.
   localparam int unsigned MIN_CYCLES = SYNC_STAGES + 2;

   generate
      if (STARTUP_CYCLES < MIN_CYCLES) begin : g_bad_start
         $error("rcosc_ready_seq: STARTUP_CYCLES too small for the synchronizer");
      end
      if (OFF_CYCLES < MIN_CYCLES) begin : g_bad_off
         $error("rcosc_ready_seq: OFF_CYCLES too small for the synchronizer");
      end
   endgenerate

   localparam int unsigned START_LAST = STARTUP_CYCLES - MIN_CYCLES;
   localparam int unsigned OFF_LAST   = OFF_CYCLES - MIN_CYCLES;
   localparam int unsigned CNT_MAX    = (START_LAST > OFF_LAST) ? START_LAST : OFF_LAST;
   localparam int unsigned CNT_W      = width_for(CNT_MAX);
   localparam logic [CNT_W-1:0] START_LAST_C = CNT_W'(START_LAST);
   localparam logic [CNT_W-1:0] OFF_LAST_C   = CNT_W'(OFF_LAST);

   logic             en_s;
   osc_state_e       state;
   logic [CNT_W-1:0] cnt;

   rcosc_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_en_sync (
      .clk   (osc_clk),
      .rst_n (osc_rst_n),
      .d     (en_async),
      .q     (en_s)
   );

   always_ff @(posedge osc_clk or negedge osc_rst_n) begin
      if (!osc_rst_n) begin
         state <= OSC_OFF;
         cnt   <= '0;
      end else begin
         unique case (state)
            OSC_OFF: begin
               if (en_s) begin
                  state <= OSC_STARTING;
                  cnt   <= '0;
               end
            end
            OSC_STARTING: begin
               if (!en_s) begin
                  state <= OSC_OFF;
               end else if (cnt == START_LAST_C) begin
                  state <= OSC_READY;
                  cnt   <= '0;
               end else begin
                  cnt <= cnt + 1'b1;
               end
            end
            OSC_READY: begin
               if (!en_s) begin
                  state <= OSC_DRAINING;
                  cnt   <= '0;
               end
            end
            OSC_DRAINING: begin
               if (en_s) begin
                  state <= OSC_READY;
               end else if (cnt == OFF_LAST_C) begin
                  state <= OSC_OFF;
                  cnt   <= '0;
               end else begin
                  cnt <= cnt + 1'b1;
               end
            end
            default: begin
               state <= OSC_OFF;
               cnt   <= '0;
            end
         endcase
      end
   end

   // Single register bit, safe to hand to another clock domain.
   assign ready_osc = state[1];
endmodule

// File: rtl/rcosc_bus_if.sv
module rcosc_bus_if
   import rcosc_pkg::*;
#(
   parameter int unsigned DATA_W      = 8,
   parameter int unsigned TRIM_W      = 5,
   parameter int unsigned TRIM_RESET  = 16,
   parameter bit          RESET_EN    = 1'b1,
   parameter int unsigned SWITCH_WAIT = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic              rd_en,
   input  logic [DATA_W-1:0] wdata,
   input  logic              clk_switching,
   input  logic              hw_set,
   input  logic              rc_in_use,
   input  logic              ready_i,
   output logic              en_o,
   output logic [TRIM_W-1:0] trim_o,
   output logic              wait_req,
   output logic [DATA_W-1:0] rdata
);
   localparam int unsigned WORD_W = TRIM_LSB + TRIM_W;

   generate
      if (DATA_W < WORD_W) begin : g_bad_data
         $error("rcosc_bus_if: DATA_W too narrow for the control word");
      end
      if (SWITCH_WAIT > 2) begin : g_bad_wait
         $error("rcosc_bus_if: SWITCH_WAIT must be 0, 1 or 2");
      end
      if (TRIM_RESET >= (1 << TRIM_W)) begin : g_bad_trim
         $error("rcosc_bus_if: TRIM_RESET does not fit the trim field");
      end
   endgenerate

   logic access;
   logic fire_wr;
   assign access  = wr_en | rd_en;
   assign fire_wr = wr_en & ~wait_req;

   generate
      if (SWITCH_WAIT == 0) begin : g_no_wait
         assign wait_req = 1'b0;
      end else begin : g_wait
         localparam int unsigned WC_W = width_for(SWITCH_WAIT);
         localparam logic [WC_W-1:0] WAIT_LOAD = WC_W'(SWITCH_WAIT - 1);
         logic            held;
         logic [WC_W-1:0] wcnt;

         assign wait_req = access & (held ? (wcnt != '0) : clk_switching);

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               held <= 1'b0;
               wcnt <= '0;
            end else if (!access) begin
               held <= 1'b0;
               wcnt <= '0;
            end else if (!held) begin
               if (clk_switching) begin
                  held <= 1'b1;
                  wcnt <= WAIT_LOAD;
               end
            end else if (wcnt != '0) begin
               wcnt <= wcnt - 1'b1;
            end else begin
               held <= 1'b0;
            end
         end
      end
   endgenerate

   // Enable: hardware set dominates, a clear is refused while in use.
   logic en_next;
   always_comb begin
      en_next = en_o;
      if (fire_wr) begin
         if (wdata[EN_BIT])  en_next = 1'b1;
         else if (!rc_in_use) en_next = 1'b0;
      end
      if (hw_set) en_next = 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_o   <= RESET_EN;
         trim_o <= TRIM_W'(TRIM_RESET);
      end else begin
         en_o <= en_next;
         if (fire_wr) trim_o <= wdata[TRIM_LSB +: TRIM_W];
      end
   end

   always_comb begin
      rdata              = '0;
      rdata[EN_BIT]      = en_o;
      rdata[RDY_BIT]     = ready_i;
      rdata[ZERO_BIT]    = 1'b0;
      rdata[TRIM_LSB +: TRIM_W] = trim_o;
   end
endmodule

// File: rtl/rcosc_ctrl.sv
module rcosc_ctrl #(
   parameter int unsigned DATA_W         = 8,
   parameter int unsigned CAL_W          = 8,
   parameter int unsigned TRIM_W         = 5,
   parameter int unsigned TRIM_RESET     = 16,
   parameter bit          RESET_EN       = 1'b1,
   parameter int unsigned STARTUP_CYCLES = 64,
   parameter int unsigned OFF_CYCLES     = 6,
   parameter int unsigned SYNC_STAGES    = 2,
   parameter int unsigned SWITCH_WAIT    = 2,
   parameter bit          SATURATE       = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              osc_clk,
   input  logic              wr_en,
   input  logic              rd_en,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] rdata,
   output logic              wait_req,
   input  logic              clk_switching,
   input  logic              lowpower_exit,
   input  logic              ext_osc_fail,
   input  logic              ext_osc_in_use,
   input  logic              rc_in_use,
   input  logic [CAL_W-1:0]  factory_cal,
   output logic              osc_en,
   output logic              osc_ready,
   output logic [CAL_W-1:0]  trim_code
);
   logic              hw_set;
   logic              osc_rst_n;
   logic              ready_osc;
   logic [TRIM_W-1:0] trim;

   assign hw_set = lowpower_exit | (ext_osc_fail & ext_osc_in_use);

   // Reset for the oscillator domain: asserted at once, released in step.
   rcosc_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_osc_rst (
      .clk   (osc_clk),
      .rst_n (rst_n),
      .d     (1'b1),
      .q     (osc_rst_n)
   );

   rcosc_bus_if #(
      .DATA_W      (DATA_W),
      .TRIM_W      (TRIM_W),
      .TRIM_RESET  (TRIM_RESET),
      .RESET_EN    (RESET_EN),
      .SWITCH_WAIT (SWITCH_WAIT)
   ) u_bus (
      .clk           (clk),
      .rst_n         (rst_n),
      .wr_en         (wr_en),
      .rd_en         (rd_en),
      .wdata         (wdata),
      .clk_switching (clk_switching),
      .hw_set        (hw_set),
      .rc_in_use     (rc_in_use),
      .ready_i       (osc_ready),
      .en_o          (osc_en),
      .trim_o        (trim),
      .wait_req      (wait_req),
      .rdata         (rdata)
   );

   rcosc_ready_seq #(
      .STARTUP_CYCLES (STARTUP_CYCLES),
      .OFF_CYCLES     (OFF_CYCLES),
      .SYNC_STAGES    (SYNC_STAGES)
   ) u_seq (
      .osc_clk   (osc_clk),
      .osc_rst_n (osc_rst_n),
      .en_async  (osc_en),
      .ready_osc (ready_osc)
   );

   rcosc_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_rdy_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (ready_osc),
      .q     (osc_ready)
   );

   rcosc_trim_sum #(
      .CAL_W    (CAL_W),
      .TRIM_W   (TRIM_W),
      .SATURATE (SATURATE)
   ) u_trim (
      .cal  (factory_cal),
      .trim (trim),
      .code (trim_code)
   );
endmodule

// File: rtl/rcosc_ctrl_chk.sv
module rcosc_ctrl_chk #(
   parameter int unsigned DATA_W      = 8,
   parameter int unsigned CAL_W       = 8,
   parameter int unsigned SWITCH_WAIT = 2,
   parameter bit          SATURATE    = 1'b1
) (
   input logic              clk,
   input logic              rst_n,
   input logic              wr_en,
   input logic              rd_en,
   input logic [DATA_W-1:0] rdata,
   input logic              wait_req,
   input logic              clk_switching,
   input logic              lowpower_exit,
   input logic              ext_osc_fail,
   input logic              ext_osc_in_use,
   input logic              rc_in_use,
   input logic [CAL_W-1:0]  factory_cal,
   input logic              osc_en,
   input logic [CAL_W-1:0]  trim_code
);
   logic [2:0] wait_run;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        wait_run <= '0;
      else if (wait_req) wait_run <= wait_run + 3'd1;
      else               wait_run <= '0;
   end

   assert_lowpower_set_R6: assert property (@(posedge clk) disable iff (!rst_n)
      lowpower_exit |=> osc_en);

   assert_fail_set_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (ext_osc_fail && ext_osc_in_use) |=> osc_en);

   assert_in_use_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (rc_in_use && osc_en) |=> osc_en);

   assert_zero_bit_R2: assert property (@(posedge clk) disable iff (!rst_n)
      rdata[2] == 1'b0);

   generate
      if (SATURATE) begin : g_sat_chk
         assert_no_wrap_R3: assert property (@(posedge clk) disable iff (!rst_n)
            trim_code >= factory_cal);
      end
   endgenerate

   assert_wait_needs_access_R10: assert property (@(posedge clk) disable iff (!rst_n)
      wait_req |-> (wr_en || rd_en));

   assert_wait_bound_R10: assert property (@(posedge clk) disable iff (!rst_n)
      wait_req |-> (wait_run < 3'(SWITCH_WAIT)));

   assert_no_switch_no_wait_R10: assert property (@(posedge clk) disable iff (!rst_n)
      ((wr_en || rd_en) && !clk_switching && wait_run == 3'd0) |-> !wait_req);
endmodule

bind rcosc_ctrl rcosc_ctrl_chk #(
   .DATA_W      (DATA_W),
   .CAL_W       (CAL_W),
   .SWITCH_WAIT (SWITCH_WAIT),
   .SATURATE    (SATURATE)
) u_chk (
   .clk            (clk),
   .rst_n          (rst_n),
   .wr_en          (wr_en),
   .rd_en          (rd_en),
   .rdata          (rdata),
   .wait_req       (wait_req),
   .clk_switching  (clk_switching),
   .lowpower_exit  (lowpower_exit),
   .ext_osc_fail   (ext_osc_fail),
   .ext_osc_in_use (ext_osc_in_use),
   .rc_in_use      (rc_in_use),
   .factory_cal    (factory_cal),
   .osc_en         (osc_en),
   .trim_code      (trim_code)
);

// File: tb/rcosc_ctrl_tb.sv
module rcosc_ctrl_tb;
   localparam int unsigned STARTUP = 8;

   logic       clk = 1'b0;
   logic       osc_clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       wr_en = 1'b0, rd_en = 1'b0;
   logic [7:0] wdata = '0;
   logic [7:0] rdata;
   logic       wait_req;
   logic       clk_switching = 1'b0, lowpower_exit = 1'b0;
   logic       ext_osc_fail = 1'b0, ext_osc_in_use = 1'b0, rc_in_use = 1'b0;
   logic [7:0] factory_cal = 8'd100;
   logic       osc_en, osc_ready;
   logic [7:0] trim_code;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   typedef struct {
      logic [7:0] data;
      string      tag;
   } exp_t;
   exp_t exp_q[$];
   event rd_ev;

   always #2 clk = ~clk;              // 250 MHz bus clock
   initial begin                      // oscillator: 12 ns, edges at 3 mod 4
      #3;
      forever begin
         osc_clk = 1'b1; #6;
         osc_clk = 1'b0; #6;
      end
   end

   rcosc_ctrl #(.STARTUP_CYCLES(STARTUP)) u_dut (
      .clk(clk), .rst_n(rst_n), .osc_clk(osc_clk),
      .wr_en(wr_en), .rd_en(rd_en), .wdata(wdata), .rdata(rdata),
      .wait_req(wait_req), .clk_switching(clk_switching),
      .lowpower_exit(lowpower_exit), .ext_osc_fail(ext_osc_fail),
      .ext_osc_in_use(ext_osc_in_use), .rc_in_use(rc_in_use),
      .factory_cal(factory_cal), .osc_en(osc_en), .osc_ready(osc_ready),
      .trim_code(trim_code)
   );

   task automatic check_eq(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
      end
   endtask

   // Monitor: pops the expected read result when a read completes.
   always @(rd_ev) begin
      exp_t e;
      if (exp_q.size() == 0) begin
         check_eq("scoreboard empty", 32'd1, 32'd0);
      end else begin
         e = exp_q.pop_front();
         check_eq(e.tag, {24'd0, rdata}, {24'd0, e.data});
      end
   end

   task automatic bus_write(input logic [7:0] d, output int nwait);
      nwait = 0;
      @(negedge clk);
      wr_en = 1'b1; wdata = d;
      #1;
      while (wait_req) begin
         @(negedge clk); #1; nwait++;
      end
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic bus_read(input logic [7:0] exp, input string tag, output int nwait);
      exp_t e;
      e.data = exp; e.tag = tag;
      exp_q.push_back(e);
      nwait = 0;
      @(negedge clk);
      rd_en = 1'b1;
      #1;
      while (wait_req) begin
         @(negedge clk); #1; nwait++;
      end
      -> rd_ev;
      @(negedge clk);
      rd_en = 1'b0;
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   initial begin
      #150000;
      if (!done) begin
         errors++; checks++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      int nw;
      idle(3);
      rst_n = 1'b1;
      #1;
      // R1 reset values
      check_eq("R1 enable after reset", osc_en, 1);
      check_eq("R1 ready after reset", osc_ready, 0);
      check_eq("R1 trim code 100+16", trim_code, 116);
      idle(60);

      // R2/R4 read after startup: trim16, bit2 0, ready 1, en 1
      bus_read(8'h83, "R2 read control word", nw);
      check_eq("R10 read without switch waits", nw, 0);

      // R8 clear refused while in use
      rc_in_use = 1'b1;
      bus_write(8'h80, nw);
      check_eq("R8 clear ignored while in use", osc_en, 1);
      check_eq("R10 write without switch waits", nw, 0);
      rc_in_use = 1'b0;
      idle(10);

      // R5 exact fall timing
      fork
         bus_write(8'h80, nw);
         begin
            @(negedge osc_en);
            repeat (6) @(posedge osc_clk);
            #1 check_eq("R5 ready held through 6th osc edge", osc_ready, 1);
            #7 check_eq("R5 ready low after 6 osc edges", osc_ready, 0);
         end
      join
      check_eq("R5 enable cleared", osc_en, 0);
      idle(10);
      bus_read(8'h80, "R5 read after fall", nw);

      // R4 exact rise timing
      fork
         bus_write(8'h81, nw);
         begin
            @(posedge osc_en);
            repeat (STARTUP) @(posedge osc_clk);
            #1 check_eq("R4 ready low through startup edge", osc_ready, 0);
            #7 check_eq("R4 ready high after startup", osc_ready, 1);
         end
      join

      // R6 lowpower exit
      bus_write(8'h80, nw);
      idle(30);
      @(negedge clk); lowpower_exit = 1'b1;
      @(negedge clk); lowpower_exit = 1'b0;
      check_eq("R6 lowpower exit sets enable", osc_en, 1);

      // R7 failure only with external oscillator in use
      bus_write(8'h80, nw);
      idle(30);
      @(negedge clk); ext_osc_fail = 1'b1;
      @(negedge clk); ext_osc_fail = 1'b0;
      idle(2);
      check_eq("R7 failure ignored when external not in use", osc_en, 0);
      ext_osc_in_use = 1'b1;
      @(negedge clk); ext_osc_fail = 1'b1;
      @(negedge clk); ext_osc_fail = 1'b0;
      check_eq("R7 failure sets enable", osc_en, 1);
      ext_osc_in_use = 1'b0;

      // R9 same-cycle clear and hardware set
      @(negedge clk);
      wr_en = 1'b1; wdata = 8'h80; lowpower_exit = 1'b1;
      @(negedge clk);
      wr_en = 1'b0; lowpower_exit = 1'b0;
      check_eq("R9 hardware set beats clear", osc_en, 1);

      // R3 trim sum and saturation
      bus_write(8'h29, nw);                        // trim 5, en 1
      check_eq("R3 trim 100+5", trim_code, 105);
      factory_cal = 8'd250;
      bus_write(8'hF9, nw);                        // trim 31
      #1 check_eq("R3 saturate 250+31", trim_code, 255);
      bus_write(8'h19, nw);                        // trim 3
      #1 check_eq("R3 250+3", trim_code, 253);
      factory_cal = 8'd0;
      bus_write(8'h01, nw);
      #1 check_eq("R3 zero", trim_code, 0);

      // R2 bits 2:1 not writable
      idle(40);
      bus_write(8'hFF, nw);
      bus_read(8'hFB, "R2 bits 2:1 ignored on write", nw);

      // R10/R11 wait states during a switch
      clk_switching = 1'b1;
      fork
         bus_write(8'hF8, nw);
         begin
            @(negedge clk); @(negedge clk);
            #1 check_eq("R11 no effect during wait", osc_en, 1);
         end
      join
      check_eq("R10 write waits during switch", nw, 2);
      check_eq("R11 write lands after waits", osc_en, 0);
      bus_read(8'hFA, "R10 read during switch", nw);
      check_eq("R10 read waits during switch", nw, 2);
      clk_switching = 1'b0;

      idle(5);
      if (exp_q.size() != 0) check_eq("scoreboard drained", exp_q.size(), 0);
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule